// File: doc/BRIEF.md
# Sixteen-Line Interrupt Aggregator

This block collects up to sixteen interrupt requests from board peripherals and presents them to a host processor as one level-sensitive interrupt line. Each request input passes through a two-flop synchronizer. Its synchronized level then sets a sticky bit in a pending register. A per-line enable mask decides which pending bits may drive the summary output. The summary output stays high for as long as any line is both pending and enabled.

The host reaches the block through a simple synchronous 16-bit register port. The port has an address, a write strobe, a read strobe and separate write and read data buses. The enable mask has no plain write address. The host enables lines by writing ones to a mask-set address and disables them by writing ones to a mask-clear address. Pending bits are cleared by writing ones to the pending address. A fourth address returns the synchronized live input levels. A typical service routine reads the pending and mask registers, handles every line that is set in both, and then writes the serviced bits back to the pending address.

Top module: `irq_agg`

## Requirements
- R1: After reset the enable mask is 0x0000, the pending register is 0x0000 and `irqOut` is low.
- R2: Input line n maps to bit n of every register. A high level on `irqIn[n]` sets pending bit n at the third rising clock edge after the level is applied. The bit stays set after the input returns low.
- R3: Writing to offset 0x16 clears every pending bit written as 1 and leaves bits written as 0 unchanged. Reading 0x16 returns the pending register.
- R4: Writing to offset 0x1A enables every line written as 1 and leaves the other lines unchanged. Reading 0x1A returns the enable mask, with 1 meaning enabled.
- R5: Writing to offset 0x1C disables every line written as 1 and leaves the other lines unchanged. Reading 0x1C also returns the enable mask.
- R6: `irqOut` is active high and is high exactly while the bitwise AND of the pending register and the enable mask is nonzero. It falls only as a result of a host write.
- R7: Reading offset 0x18 returns the synchronized live input levels, with no masking or latching. A level is visible there after the second rising edge after it is applied.
- R8: A pending bit whose synchronized input is high stays set even through a same-cycle clear write. A still-active level source is therefore never lost.
- R9: Reading an unmapped offset returns 0x0000. `busRdData` is 0x0000 whenever `busRdEn` is low. Reads never change the mask or the pending register.
- R10: Writing 0xFFFF to 0x1C and then 0xFFFF to 0x16, with all inputs low, leaves every line disabled, nothing pending and `irqOut` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 16 | Asynchronous peripheral interrupt levels, active high |
| busAddr | input | 8 | Register byte offset |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busRdEn | input | 1 | Read strobe; read data is valid in the same cycle |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data, zero when no read is active |
| irqOut | output | 1 | Summary interrupt, active high, level |

## Verification
The bench builds the block with its default parameters: sixteen lines, 16-bit data, an 8-bit offset and a two-stage synchronizer. These defaults make the top line (bit 15) and the bottom line (bit 0) directly reachable. They also let the bench count the synchronizer latency exactly, by reading the pending and live registers one edge apart. Using the real register offsets means the unmapped neighbours 0x17 and 0x1E, which sit next to the decoded addresses, can be probed. It also lets the bench drive a clear write while a source is still high.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Read source chosen by the decoder for the current cycle
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_PEND = 2'd1,
    RD_LIVE = 2'd2,
    RD_MASK = 2'd3
  } rdSel_e;

  // Strobes passed from the decoder to the register datapath
  typedef struct packed {
    logic   wrPend;
    logic   wrMaskSet;
    logic   wrMaskClr;
    rdSel_e rdSel;
  } ctrlStb_t;

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  localparam int LAST = STAGES - 1;

  for (genvar ln = 0; ln < WIDTH; ln++) begin : g_line
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chain <= '0;
      end else begin
        chain <= {chain[STAGES-2:0], asyncIn[ln]};
      end
    end

    assign syncOut[ln] = chain[LAST];
  end

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int          ADDR_W        = 8,
  parameter logic [7:0]  OFS_PEND      = 8'h16,
  parameter logic [7:0]  OFS_LIVE      = 8'h18,
  parameter logic [7:0]  OFS_MASK_SET  = 8'h1A,
  parameter logic [7:0]  OFS_MASK_CLR  = 8'h1C
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  output ctrlStb_t          ctrlStb
);

  logic hitPend, hitLive, hitSet, hitClr;

  assign hitPend = (busAddr == ADDR_W'(OFS_PEND));
  assign hitLive = (busAddr == ADDR_W'(OFS_LIVE));
  assign hitSet  = (busAddr == ADDR_W'(OFS_MASK_SET));
  assign hitClr  = (busAddr == ADDR_W'(OFS_MASK_CLR));

  always_comb begin
    ctrlStb           = '0;
    ctrlStb.rdSel     = RD_NONE;
    ctrlStb.wrPend    = busWrEn && hitPend;
    ctrlStb.wrMaskSet = busWrEn && hitSet;
    ctrlStb.wrMaskClr = busWrEn && hitClr;
    if (busRdEn) begin
      if (hitPend)              ctrlStb.rdSel = RD_PEND;
      else if (hitLive)         ctrlStb.rdSel = RD_LIVE;
      else if (hitSet || hitClr) ctrlStb.rdSel = RD_MASK;
      else                      ctrlStb.rdSel = RD_NONE;
    end
  end

endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStb_t         ctrlStb,
  input  logic [LINES-1:0] wrData,
  input  logic [LINES-1:0] syncLvl,
  output logic [LINES-1:0] rdData,
  output logic             irqOut
);

  logic [LINES-1:0] pendQ, maskQ;
  logic [LINES-1:0] pendClr, maskSet, maskClr;

  assign pendClr = ctrlStb.wrPend    ? wrData : '0;
  assign maskSet = ctrlStb.wrMaskSet ? wrData : '0;
  assign maskClr = ctrlStb.wrMaskClr ? wrData : '0;

  // Live level sets the bit after the clear is applied: set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
    end else begin
      pendQ <= (pendQ & ~pendClr) | syncLvl;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
    end else begin
      maskQ <= (maskQ | maskSet) & ~maskClr;
    end
  end

  always_comb begin
    unique case (ctrlStb.rdSel)
      RD_PEND: rdData = pendQ;
      RD_LIVE: rdData = syncLvl;
      RD_MASK: rdData = maskQ;
      default: rdData = '0;
    endcase
  end

  assign irqOut = |(pendQ & maskQ);

  AST_PEND_NO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlStb.wrPend |=> ((pendQ & $past(pendQ)) == $past(pendQ))); // R3

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrlStb.wrMaskSet || ctrlStb.wrMaskClr) |=> $stable(maskQ)); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (syncLvl != '0) |=> ((pendQ & $past(syncLvl)) == $past(syncLvl))); // R8

  AST_MASK_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlStb.wrMaskClr && (wrData == '1)) |=> (maskQ == '0)); // R10

endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int         LINES        = 16,
  parameter int         ADDR_W       = 8,
  parameter int         SYNC_STAGES  = 2,
  parameter logic [7:0] OFS_PEND     = 8'h16,
  parameter logic [7:0] OFS_LIVE     = 8'h18,
  parameter logic [7:0] OFS_MASK_SET = 8'h1A,
  parameter logic [7:0] OFS_MASK_CLR = 8'h1C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [LINES-1:0]  irqIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [LINES-1:0]  busWrData,
  output logic [LINES-1:0]  busRdData,
  output logic              irqOut
);

  ctrlStb_t         ctrlStb;
  logic [LINES-1:0] syncLvl;

  irq_agg_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (irqIn),
    .syncOut (syncLvl)
  );

  irq_agg_ctrl #(
    .ADDR_W       (ADDR_W),
    .OFS_PEND     (OFS_PEND),
    .OFS_LIVE     (OFS_LIVE),
    .OFS_MASK_SET (OFS_MASK_SET),
    .OFS_MASK_CLR (OFS_MASK_CLR)
  ) u_ctrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .ctrlStb (ctrlStb)
  );

  irq_agg_dp #(.LINES(LINES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrlStb (ctrlStb),
    .wrData  (busWrData),
    .syncLvl (syncLvl),
    .rdData  (busRdData),
    .irqOut  (irqOut)
  );

  AST_IRQ_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqOut) |-> $past(busWrEn)); // R6

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |-> (busRdData == '0)); // R9

endmodule

// File: tb/irq_agg_bench.sv
`timescale 1ns/1ps
module irq_agg_bench;

  localparam logic [7:0] A_PEND = 8'h16;
  localparam logic [7:0] A_LIVE = 8'h18;
  localparam logic [7:0] A_MSET = 8'h1A;
  localparam logic [7:0] A_MCLR = 8'h1C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqIn = '0;
  logic [7:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [15:0] busWrData = '0;
  logic [15:0] busRdData;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  logic        idleChk = 1'b0;

  always #2.5 clk = ~clk;

  irq_agg u_irq_agg (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .busAddr(busAddr),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut)
  );

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  // Monitor: samples 1 ns before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (busRdEn) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL scoreboard: unexpected read, actual %h expected none", busRdData);
        end else begin
          logic [15:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (busRdData !== e) begin
            errors++;
            $display("FAIL %s: read @%h actual %h expected %h", t, busAddr, busRdData, e);
          end
        end
      end else if (idleChk) begin
        checks++;
        if (busRdData !== 16'h0) begin
          errors++;
          $display("FAIL R9: idle read data actual %h expected 0000", busRdData);
        end
      end
    end
  end

  // Driver tasks: entered at a falling edge, consume one cycle
  task automatic doRead(input logic [7:0] a, input logic [15:0] e, input string t);
    expQ.push_back(e);
    tagQ.push_back(t);
    busAddr = a;
    busRdEn = 1'b1;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic doWrite(input logic [7:0] a, input logic [15:0] d);
    busAddr   = a;
    busWrData = d;
    busWrEn   = 1'b1;
    @(negedge clk);
    busWrEn   = 1'b0;
  endtask

  task automatic checkIrq(input logic e, input string t);
    #1.5;
    checks++;
    if (irqOut !== e) begin
      errors++;
      $display("FAIL %s: irqOut actual %b expected %b", t, irqOut, e);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    idle(1);
    // R1 reset state
    checkIrq(1'b0, "R1");
    doRead(A_PEND, 16'h0000, "R1");
    doRead(A_MSET, 16'h0000, "R1");

    // R4 mask set
    doWrite(A_MSET, 16'h00F0);
    doRead(A_MSET, 16'h00F0, "R4");
    doWrite(A_MSET, 16'h0300);
    doRead(A_MSET, 16'h03F0, "R4");
    // R5 mask clear
    doWrite(A_MCLR, 16'h0030);
    doRead(A_MCLR, 16'h03C0, "R5");
    doRead(A_MSET, 16'h03C0, "R5");

    // R2 / R7 latency and latching
    irqIn = 16'h0041;
    idle(1);
    doRead(A_PEND, 16'h0000, "R2");
    doRead(A_LIVE, 16'h0041, "R7");
    doRead(A_PEND, 16'h0041, "R2");
    irqIn = 16'h0000;
    idle(3);
    doRead(A_PEND, 16'h0041, "R2");
    doRead(A_LIVE, 16'h0000, "R7");
    checkIrq(1'b1, "R6");

    // R3 write-one-to-clear pending
    doWrite(A_PEND, 16'h0040);
    doRead(A_PEND, 16'h0001, "R3");
    checkIrq(1'b0, "R6");
    doWrite(A_PEND, 16'h0000);
    doRead(A_PEND, 16'h0001, "R3");

    // R6 via mask
    doWrite(A_MSET, 16'h0001);
    checkIrq(1'b1, "R6");
    doWrite(A_MCLR, 16'h0001);
    checkIrq(1'b0, "R6");

    // R8 set wins over clear while source is high
    irqIn = 16'h8000;
    idle(3);
    doWrite(A_PEND, 16'hFFFF);
    doRead(A_PEND, 16'h8000, "R8");
    irqIn = 16'h0000;
    idle(3);
    doWrite(A_PEND, 16'h8000);
    doRead(A_PEND, 16'h0000, "R8");

    // R9 unmapped offsets, idle read bus, reads leave state alone
    idleChk = 1'b1;
    idle(2);
    idleChk = 1'b0;
    doRead(8'h00, 16'h0000, "R9");
    doRead(8'h17, 16'h0000, "R9");
    doRead(8'h1E, 16'h0000, "R9");
    doRead(A_MSET, 16'h03C0, "R9");

    // R10 shutdown sequence
    doWrite(A_MSET, 16'hFFFF);
    irqIn = 16'h1234;
    idle(3);
    irqIn = 16'h0000;
    idle(3);
    checkIrq(1'b1, "R10");
    doWrite(A_MCLR, 16'hFFFF);
    doWrite(A_PEND, 16'hFFFF);
    doRead(A_MSET, 16'h0000, "R10");
    doRead(A_PEND, 16'h0000, "R10");
    checkIrq(1'b0, "R10");

    idle(2);
    checks++;
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: leftover items actual %0d expected 0", expQ.size());
    end
    report();
    $finish;
  end

endmodule